// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Software Force

The block gathers interrupt events from internal peripherals onto fifteen request lines, numbered 1 to 15. Each event sets a sticky pending bit. A per-line mask blocks lines from reaching the processor. Software clears pending bits by writing ones to a clear register. A force register lets software drive any line active without a peripheral event, so every line can be tested.

The controller always presents one request level to the processor. That level is the highest-numbered line that is active (pending or forced) and not masked. The processor answers with an acknowledge and the level it is taking. The acknowledge removes both the pending bit and the force bit of that line.

Software reaches the four registers over a word-wide bus with a word index, a write strobe, write data and a combinational read path. Bit 0 of every register is unused. Shaping of external interrupt pins, as edge or level, is outside this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, pending and force read as zero, mask reads 0x0000FFFE (every line blocked), and the request level is 0.
- R2: A one on `irq_src_i[k]` (k = 1..15) in a cycle makes pending bit k read as one from the next cycle on. Bit 0 of `irq_src_i` is ignored, and pending bit 0 always reads 0.
- R3: The pending register sits at word index 0 and is read-only. A bus write to index 0 changes no register.
- R4: The mask register sits at word index 1 and is readable and writable in bits 15:1. A mask bit of 1 blocks that line. Bit 0 and bits above 15 read as 0.
- R5: The clear register sits at word index 2. Writing it clears every pending bit whose write-data bit is 1 and leaves the other pending bits unchanged.
- R6: If a source event on a line arrives in the same cycle as a clear of that line, by register write or by acknowledge, the pending bit stays set.
- R7: The force register sits at word index 3 and is readable and writable in bits 15:1. A set force bit acts as an active request on its line but does not set the pending bit.
- R8: `irq_level_o` equals the highest line number whose pending or force bit is 1 and whose mask bit is 0. It is 0 when no such line exists. It follows register state within the same cycle.
- R9: A masked line still records events in pending, but it never appears on `irq_level_o` while the mask bit is set.
- R10: An acknowledge with a nonzero level clears that line's pending bit and force bit at the next edge. An acknowledge clear of a force bit takes priority over a force write in the same cycle. An acknowledge with level 0 has no effect.
- R11: Reading word index 2 (the clear register) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 16 | Event pulses from peripherals, one per line; bit 0 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index (0 pending, 1 mask, 2 clear, 3 force) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the indexed register, combinational |
| irq_level_o | output | 4 | Requested interrupt level; 0 when there is no request |
| irq_ack_i | input | 1 | Processor acknowledge strobe |
| irq_ack_level_i | input | 4 | Level being acknowledged |

## Verification
Directed patterns come first. Two peripheral lines fire together while every line is masked, which separates event capture from request presentation. Single-line masking then shows that the mask selects lines and does not merely reorder them. A clear that collides with a fresh event on the same line exposes which of the two wins. Force writes mixed with pending bits, then acknowledges with and without a colliding source, show that acknowledge touches exactly one line in both registers. Last comes a long random mix of sparse events, bus writes to every index and acknowledges, compared every cycle against a behavioural model. This mix catches priority-order and write-decode slips that the directed patterns miss.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  typedef enum logic [1:0] {
    REG_PEND  = 2'd0,
    REG_MASK  = 2'd1,
    REG_CLR   = 2'd2,
    REG_FORCE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_if.sv
`timescale 1ns/1ps
module irq_reg_if #(
  parameter int VEC_W  = 16,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_level_i,
  input  logic [VEC_W-1:0]  pend_i,
  input  logic [VEC_W-1:0]  mask_i,
  input  logic [VEC_W-1:0]  force_i,
  output logic              wr_mask_o,
  output logic              wr_clr_o,
  output logic              wr_force_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [DATA_W-1:0] rdata_o
);
  import prio_irq_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  // pending index decodes to no strobe: read-only
  assign wr_mask_o  = we_i && (sel == REG_MASK);
  assign wr_clr_o   = we_i && (sel == REG_CLR);
  assign wr_force_o = we_i && (sel == REG_FORCE);

  always_comb begin
    ack_vec_o = '0;
    for (int i = 1; i < VEC_W; i++) begin
      if (ack_i && (int'(ack_level_i) == i)) ack_vec_o[i] = 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      REG_PEND:  rdata_o = DATA_W'(pend_i);
      REG_MASK:  rdata_o = DATA_W'(mask_i);
      REG_FORCE: rdata_o = DATA_W'(force_i);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_line_bank.sv
`timescale 1ns/1ps
module irq_line_bank #(
  parameter int VEC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] src_i,
  input  logic             wr_mask_i,
  input  logic             wr_clr_i,
  input  logic             wr_force_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic [VEC_W-1:0] pend_o,
  output logic [VEC_W-1:0] mask_o,
  output logic [VEC_W-1:0] force_o
);
  for (genvar i = 0; i < VEC_W; i++) begin : g_line
    if (i == 0) begin : g_unused
      assign pend_o[i]  = 1'b0;
      assign mask_o[i]  = 1'b0;
      assign force_o[i] = 1'b0;
    end else begin : g_used
      logic pend_q, mask_q, force_q;
      logic kill;
      assign kill = (wr_clr_i && wdata_i[i]) || ack_vec_i[i];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q  <= 1'b0;
          mask_q  <= 1'b1;
          force_q <= 1'b0;
        end else begin
          // a fresh event outranks any clear
          pend_q <= src_i[i] || (pend_q && !kill);
          if (wr_mask_i) mask_q <= wdata_i[i];
          if (ack_vec_i[i])    force_q <= 1'b0;
          else if (wr_force_i) force_q <= wdata_i[i];
        end
      end

      assign pend_o[i]  = pend_q;
      assign mask_o[i]  = mask_q;
      assign force_o[i] = force_q;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int VEC_W = 16,
  parameter int LVL_W = 4
) (
  input  logic [VEC_W-1:0] req_i,
  output logic [LVL_W-1:0] level_o
);
  always_comb begin
    level_o = '0;
    for (int i = 1; i < VEC_W; i++) begin
      if (req_i[i]) level_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NUM_LINES = 15,
  parameter int DATA_W    = 32,
  localparam int VEC_W    = NUM_LINES + 1,
  localparam int LVL_W    = $clog2(NUM_LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_W-1:0]  irq_src_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [LVL_W-1:0]  irq_level_o,
  input  logic              irq_ack_i,
  input  logic [LVL_W-1:0]  irq_ack_level_i
);
  logic [VEC_W-1:0] pend_q, mask_q, force_q, ack_vec, req_vec;
  logic             wr_mask, wr_clr, wr_force;

  irq_reg_if #(.VEC_W(VEC_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) i_reg_if (
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .ack_i       (irq_ack_i),
    .ack_level_i (irq_ack_level_i),
    .pend_i      (pend_q),
    .mask_i      (mask_q),
    .force_i     (force_q),
    .wr_mask_o   (wr_mask),
    .wr_clr_o    (wr_clr),
    .wr_force_o  (wr_force),
    .ack_vec_o   (ack_vec),
    .rdata_o     (reg_rdata_o)
  );

  irq_line_bank #(.VEC_W(VEC_W)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (irq_src_i),
    .wr_mask_i  (wr_mask),
    .wr_clr_i   (wr_clr),
    .wr_force_i (wr_force),
    .wdata_i    (reg_wdata_i[VEC_W-1:0]),
    .ack_vec_i  (ack_vec),
    .pend_o     (pend_q),
    .mask_o     (mask_q),
    .force_o    (force_q)
  );

  assign req_vec = (pend_q | force_q) & ~mask_q;

  irq_prio_pick #(.VEC_W(VEC_W), .LVL_W(LVL_W)) i_pick (
    .req_i   (req_vec),
    .level_o (irq_level_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int VEC_W = 16,
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VEC_W-1:0] irq_src_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [VEC_W-1:0] wdata_lo,
  input logic             irq_ack_i,
  input logic [LVL_W-1:0] irq_ack_level_i,
  input logic [LVL_W-1:0] irq_level_o,
  input logic [VEC_W-1:0] pend_q,
  input logic [VEC_W-1:0] mask_q,
  input logic [VEC_W-1:0] force_q
);
  localparam logic [VEC_W-1:0] LINES = ~VEC_W'(1);
  logic [VEC_W-1:0] act;
  assign act = (pend_q | force_q) & ~mask_q;

  p_src_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(irq_src_i & LINES)) == $past(irq_src_i & LINES)));

  p_pend_rise_only_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(irq_src_i)) == '0));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2) |=> ((pend_q & $past(wdata_lo & ~irq_src_i)) == '0));

  p_level_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (act[irq_level_o] && !mask_q[irq_level_o]));

  p_level_highest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act >> irq_level_o) >> 1) == '0);

  p_ack_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_ack_level_i != '0 && !irq_src_i[irq_ack_level_i])
      |=> !pend_q[$past(irq_ack_level_i)]);

  p_ack_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_ack_level_i != '0) |=> !force_q[$past(irq_ack_level_i)]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VEC_W(VEC_W), .LVL_W(LVL_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .irq_src_i       (irq_src_i),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .wdata_lo        (reg_wdata_i[VEC_W-1:0]),
  .irq_ack_i       (irq_ack_i),
  .irq_ack_level_i (irq_ack_level_i),
  .irq_level_o     (irq_level_o),
  .pend_q          (pend_q),
  .mask_q          (mask_q),
  .force_q         (force_q)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  level;
  logic        ack = 1'b0;
  logic [3:0]  ack_lvl = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_level_o(level), .irq_ack_i(ack), .irq_ack_level_i(ack_lvl)
  );

  // behavioural reference
  bit [15:0] m_pend, m_mask, m_force;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_mask = 16'hFFFE; m_force = 0;
    end else begin
      for (int k = 1; k < 16; k++) begin
        bit acked, cleared;
        acked   = ack && (ack_lvl == k);
        cleared = we && addr == 2 && wdata[k];
        if (src[k]) m_pend[k] = 1;
        else if (acked || cleared) m_pend[k] = 0;
        if (we && addr == 1) m_mask[k] = wdata[k];
        if (acked) m_force[k] = 0;
        else if (we && addr == 3) m_force[k] = wdata[k];
      end
    end
  end

  function automatic int exp_level();
    for (int k = 15; k >= 1; k--)
      if ((m_pend[k] || m_force[k]) && !m_mask[k]) return k;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd();
    case (addr)
      2'd0: return {16'h0, m_pend};
      2'd1: return {16'h0, m_mask};
      2'd3: return {16'h0, m_force};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(level == exp_level(), "R8 level", level, exp_level());
    chk(rdata == exp_rd(), "R4/R7 readback", rdata, exp_rd());
  endtask

  task automatic cyc(input logic [15:0] s, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input logic k, input logic [3:0] kl);
    src = s; we = w; addr = a; wdata = d; ack = k; ack_lvl = kl;
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    cyc(0, 0, a, 0, 0, 0);
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic lv(input int exp, input string req);
    chk(level == exp, req, level, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    lv(0, "R1 level after reset");
    rd(0, 32'h0, "R1 pending reset");
    rd(1, 32'h0000FFFE, "R1 mask reset");
    rd(3, 32'h0, "R1 force reset");
    // R2 events on lines 4,5 and ignored bit 0, all masked (R9)
    cyc(16'h0031, 0, 0, 0, 0, 0);
    rd(0, 32'h30, "R2 pending capture");
    lv(0, "R9 masked lines hidden");
    // R4 mask access
    cyc(0, 1, 1, 32'h0, 0, 0);
    rd(1, 32'h0, "R4 mask write 0");
    lv(5, "R8 highest unmasked");
    cyc(0, 1, 1, 32'hFFFF_FFFF, 0, 0);
    rd(1, 32'h0000FFFE, "R4 mask unused bits");
    cyc(0, 1, 1, 32'h20, 0, 0);
    lv(4, "R9 mask line 5");
    cyc(0, 1, 1, 32'h0, 0, 0);
    // R3 pending read-only
    cyc(0, 1, 0, 32'hFFFF_FFFF, 0, 0);
    rd(0, 32'h30, "R3 pending write ignored");
    rd(1, 32'h0, "R3 mask untouched");
    // R6 clear collides with event
    cyc(16'h0010, 1, 2, 32'h10, 0, 0);
    rd(0, 32'h30, "R6 event beats clear");
    // R5 clear
    cyc(0, 1, 2, 32'h20, 0, 0);
    rd(0, 32'h10, "R5 partial clear");
    cyc(0, 1, 2, 32'h10, 0, 0);
    rd(0, 32'h0, "R5 full clear");
    rd(2, 32'h0, "R11 clear reads zero");
    lv(0, "R8 idle level");
    // R7 force
    cyc(0, 1, 3, 32'h8002, 0, 0);
    rd(3, 32'h8002, "R7 force readback");
    rd(0, 32'h0, "R7 force leaves pending");
    lv(15, "R7 forced line requests");
    // R10 ack
    cyc(0, 0, 3, 0, 1, 15);
    rd(3, 32'h0002, "R10 ack clears force");
    lv(1, "R10 next level");
    cyc(0, 1, 3, 32'h0006, 1, 2);
    rd(3, 32'h0002, "R10 ack beats force write");
    cyc(0, 0, 3, 0, 1, 0);
    rd(3, 32'h0002, "R10 ack level 0 ignored");
    cyc(0, 1, 3, 32'h0, 0, 0);
    cyc(16'h0208, 0, 0, 0, 0, 0);
    lv(9, "R8 lines 3 and 9");
    cyc(16'h0200, 0, 0, 0, 1, 9);
    rd(0, 32'h0208, "R6 event beats ack");
    cyc(0, 0, 0, 0, 1, 9);
    rd(0, 32'h0008, "R10 ack clears pending");
    lv(3, "R10 level drops");
    // random mix against the model
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] s;
      s = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      cyc(s, 1'($urandom_range(0, 2) == 0), 2'($urandom), $urandom & 32'h0003_FFFF,
          1'($urandom_range(0, 3) == 0), 4'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule